// File: doc/BRIEF.md
# Dual-Channel Detect Release Debouncer

This block filters two detect inputs against short dropouts. Each pin first passes through a two-stage synchronizer. A rise of a synchronized pin reaches that channel's status bit at once. A fall does not. The status bit, and with it the channel's share of the interrupt, stays at 1 for a programmed hold time. After that it drops to 0. If the pin comes back high before the hold time runs out, the hold is abandoned and the status never drops. The next fall starts a fresh, full hold period.

Each channel has its own 4-bit hold field, and both fields sit in one 8-bit control register that is written through a simple write strobe. The hold time is the field value times 15 ms, so it ranges from 0 to 225 ms. A free-running prescaler produces the 1 ms time base; its divisor is a parameter, so a simulation can use a short period. The timers run only while the power-on input is high. While it is low, the hold logic is idle and the status bits follow the synchronized pins. The interrupt output is the OR of the two filtered status bits.

Top module: `det_hold_filter`

## Requirements
- R1: A write with `cfg_wr_en` high loads `cfg_wr_data` into the control register on that clock edge. Bits 3..0 set the hold field of channel 0 (`det_pin[0]`) and bits 7..4 set the hold field of channel 1 (`det_pin[1]`).
- R2: During reset, and after reset until the first write, the control register is 0x00. In that state both hold fields are 0, and `det_status` and `irq` are 0 while reset is held.
- R3: With `pwr_on` high and hold field N > 0, a fall of a pin from 1 to 0 leaves that channel's status at 1 for N×15 ms, counted in whole 1 ms ticks (N×15 ticks, where the first tick falls within one tick period). The status then goes to 0.
- R4: A rise of a pin from 0 to 1 reaches the status bit three clock edges after the pin changes (two synchronizer stages plus the status register), whatever the hold field and `pwr_on`.
- R5: With a hold field of 0, the status of that channel follows its pin in both directions, with the three-edge latency of R4.
- R6: While `pwr_on` is 0, no hold is applied: the status follows the pin with the latency of R4. Dropping `pwr_on` during a hold ends the hold, and a low pin then shows as 0 within three edges.
- R7: If the pin returns to 1 during a hold, the status stays at 1 throughout. A later fall starts a new, full hold period of R3.
- R8: The two channels hold and time out independently, each with its own field.
- R9: `irq` is 1 exactly when at least one status bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on | input | 1 | Enables the hold timers when 1 |
| det_pin | input | 2 | Asynchronous detect pins, bit 0 is channel 0 |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write data |
| det_status | output | 2 | Filtered detect status per channel |
| irq | output | 1 | OR of the filtered status bits |

## Verification
The hardest cases to reach are a pin that comes back high just before its hold runs out, which must cancel the hold rather than let the status drop, and a hold that is cut short because `pwr_on` goes low. The bench reaches the first with random dropouts whose widths reach close to the programmed hold time, on random channels and with random fields, and checks every cycle that the status never falls. It then forces a full fall afterwards to confirm that the hold restarts from zero. The power-off case is directed: the bench starts a 225 ms hold, clears `pwr_on` a few cycles later, and expects the low pin to show within three edges.

// File: rtl/det_hold_pkg.sv
// Package: shared sizes for the detect release debouncer.
// Assumes two channels sharing one control register of 4-bit fields.
package det_hold_pkg;
    localparam int NUM_CH  = 2;
    localparam int FIELD_W = 4;
    localparam int CTRL_W  = NUM_CH * FIELD_W;
    localparam int STEP_MS = 15;
    localparam int MAX_TICKS = ((1 << FIELD_W) - 1) * STEP_MS;
    localparam int TICK_CNT_W = $clog2(MAX_TICKS + 1);
endpackage

// File: rtl/det_hold_sync.sv
// Module: multi-bit two-stage (parameterizable) synchronizer.
// Assumes each bit is an independent asynchronous level; no bus coherence.
module det_hold_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/det_hold_tick.sv
// Module: millisecond prescaler.
// Emits a one-cycle tick every DIV clocks while enabled; restarts its phase
// whenever the enable is low. Assumes DIV >= 1.
module det_hold_tick #(
    parameter int DIV = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    // Count clocks modulo DIV while enabled, hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = en && (div_q == LAST);
endmodule

// File: rtl/det_hold_chan.sv
// Module: one channel of the release debouncer.
// Rises pass straight to the status; a fall with a nonzero field holds the
// status high for field*STEP_MS ticks. A return to 1 cancels the hold.
// Assumes pin_s is already synchronous and tick is a one-cycle pulse.
module det_hold_chan
    import det_hold_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_on,
    input  logic               tick,
    input  logic               pin_s,
    input  logic [FIELD_W-1:0] field,
    output logic               status
);
    localparam logic [TICK_CNT_W-1:0] STEP_W = TICK_CNT_W'(STEP_MS);

    logic                  holding_q;
    logic [TICK_CNT_W-1:0] cnt_q;
    logic [TICK_CNT_W-1:0] limit;
    logic [TICK_CNT_W-1:0] cnt_nxt;
    logic                  bypass;

    // Hold length in ticks, taken live from the current field.
    always_comb begin
        limit   = TICK_CNT_W'(field) * STEP_W;
        cnt_nxt = cnt_q + 1'b1;
        bypass  = !pwr_on || (field == '0) || pin_s;
    end

    // Status, hold flag and tick count of this channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status    <= 1'b0;
            holding_q <= 1'b0;
            cnt_q     <= '0;
        end else if (bypass) begin
            status    <= pin_s;
            holding_q <= 1'b0;
            cnt_q     <= '0;
        end else if (holding_q) begin
            if (tick) begin
                if (cnt_nxt >= limit) begin
                    status    <= 1'b0;
                    holding_q <= 1'b0;
                    cnt_q     <= '0;
                end else begin
                    cnt_q <= cnt_nxt;
                end
            end
        end else if (status) begin
            holding_q <= 1'b1;
            cnt_q     <= '0;
        end
    end
endmodule

// File: rtl/det_hold_filter.sv
// Module: dual-channel detect release debouncer (top).
// Synchronizes both pins, keeps the shared control register, runs one
// prescaler and one hold channel per pin, and ORs the results into irq.
// Assumes CLK_PER_MS clocks make one millisecond.
module det_hold_filter
    import det_hold_pkg::*;
#(
    parameter int CLK_PER_MS = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic [NUM_CH-1:0] det_pin,
    input  logic              cfg_wr_en,
    input  logic [CTRL_W-1:0] cfg_wr_data,
    output logic [NUM_CH-1:0] det_status,
    output logic              irq
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [NUM_CH-1:0] pin_sync;
    logic              ms_tick;

    // Control register holding both hold fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cfg_wr_en) begin
            ctrl_q <= cfg_wr_data;
        end
    end

    det_hold_sync #(.WIDTH(NUM_CH), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (det_pin),
        .sync_out (pin_sync)
    );

    det_hold_tick #(.DIV(CLK_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pwr_on),
        .tick  (ms_tick)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        det_hold_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .pwr_on (pwr_on),
            .tick   (ms_tick),
            .pin_s  (pin_sync[g]),
            .field  (ctrl_q[g*FIELD_W +: FIELD_W]),
            .status (det_status[g])
        );
    end

    assign irq = |det_status;
endmodule

// File: rtl/det_hold_filter_chk.sv
// Module: assertion checker for the detect release debouncer, bound to the
// top. Observes synchronized pins, control fields, tick and outputs.
module det_hold_filter_chk
    import det_hold_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_on,
    input logic [NUM_CH-1:0] pin_s,
    input logic [CTRL_W-1:0] ctrl,
    input logic              tick,
    input logic [NUM_CH-1:0] status,
    input logic              irq
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        AST_RISE_PROPAGATES: assert property (@(posedge clk) disable iff (!rst_n)
            pin_s[g] |=> status[g]);                                             // R4
        AST_RISE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[g]) |-> $past(pin_s[g]));                               // R4
        AST_OFF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            !pwr_on |=> status[g] == $past(pin_s[g]));                           // R6
        AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_on && ctrl[g*FIELD_W +: FIELD_W] == '0) |=> status[g] == $past(pin_s[g])); // R5
        AST_DROP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(status[g]) && $past(pwr_on) && $past(ctrl[g*FIELD_W +: FIELD_W]) != '0
             && $past(!pin_s[g])) |-> $past(tick));                              // R3
    end
    AST_IRQ_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (|pin_s) |=> irq);                                                       // R9
endmodule

bind det_hold_filter det_hold_filter_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_on (pwr_on),
    .pin_s  (pin_sync),
    .ctrl   (ctrl_q),
    .tick   (ms_tick),
    .status (det_status),
    .irq    (irq)
);

// File: tb/test_det_hold_filter.sv
module test_det_hold_filter;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_on = 1'b0;
    logic [1:0] det_pin = 2'b00;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = 8'h00;
    logic [1:0] det_status;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    det_hold_filter #(.CLK_PER_MS(P)) i_det_hold_filter (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .det_pin(det_pin),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .det_status(det_status), .irq(irq));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lo_bound(input int f);
        return (f * 15 - 1) * P + 2;
    endfunction

    function automatic int hi_bound(input int f);
        return f * 15 * P + 5;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Drop one pin and count negedges until its status reads 0.
    task automatic measure(input int ch, input int f, input string req);
        int n;
        n = 0;
        det_pin[ch] = 1'b0;
        while (n < hi_bound(f) + 20) begin
            @(negedge clk);
            n++;
            if (det_status[ch] == 1'b0) break;
        end
        if (f == 0) chk(n == 3, req, n, 3);
        else chk(n >= lo_bound(f) && n <= hi_bound(f), req, n, f * 15 * P);
    endtask

    initial begin
        step(3);
        chk(det_status == 2'b00 && irq == 1'b0, "R2 reset outputs", int'({irq, det_status}), 0);
        rst_n = 1'b1;
        pwr_on = 1'b1;
        step(2);

        // R4: rise latency of three edges
        det_pin = 2'b01;
        step(2);
        chk(det_status[0] == 1'b0, "R4 no early rise", det_status[0], 0);
        step(1);
        chk(det_status[0] == 1'b1, "R4 rise after three edges", det_status[0], 1);
        chk(irq == 1'b1, "R9 irq one channel", irq, 1);

        // R2/R5: reset fields are zero, so falls pass straight through
        measure(0, 0, "R2 zero field after reset ch0");
        det_pin[1] = 1'b1;
        step(4);
        measure(1, 0, "R5 zero field ch1");
        chk(irq == 1'b0, "R9 irq both low", irq, 0);

        // R1/R3: ch0 field 1, ch1 field 2
        wr(8'h21);
        det_pin = 2'b11;
        step(4);
        measure(0, 1, "R3 ch0 field 1");
        measure(1, 2, "R1 R3 ch1 field 2 from bits 7..4");

        // R8: simultaneous fall, channels time out independently
        det_pin = 2'b11;
        step(4);
        det_pin = 2'b00;
        step(15 * P + 6);
        chk(det_status == 2'b10, "R8 ch0 done ch1 holding", det_status, 2);
        chk(irq == 1'b1, "R9 irq from holding channel", irq, 1);
        step(15 * P + 6);
        chk(det_status == 2'b00, "R8 both released", det_status, 0);

        // R3/R5: ch1 field 15, ch0 field 0
        wr(8'hF0);
        det_pin = 2'b11;
        step(4);
        measure(0, 0, "R5 ch0 follows with zero field");
        measure(1, 15, "R3 ch1 field 15");

        // R7: return high during hold cancels, next fall holds in full
        wr(8'h02);
        det_pin[0] = 1'b1;
        step(4);
        det_pin[0] = 1'b0;
        step(20 * P);
        det_pin[0] = 1'b1;
        step(5);
        chk(det_status[0] == 1'b1, "R7 cancelled hold keeps status", det_status[0], 1);
        measure(0, 2, "R7 full hold after restart");

        // R6: power off, fields ignored
        wr(8'hFF);
        det_pin = 2'b11;
        step(4);
        pwr_on = 1'b0;
        step(2);
        measure(0, 0, "R6 ch0 follows when power off");
        det_pin[0] = 1'b1;
        step(4);
        pwr_on = 1'b1;
        step(2);
        det_pin[0] = 1'b0;
        step(10);
        chk(det_status[0] == 1'b1, "R3 holding before power off", det_status[0], 1);
        pwr_on = 1'b0;
        step(3);
        chk(det_status[0] == 1'b0, "R6 power off ends hold", det_status[0], 0);
        pwr_on = 1'b1;

        // R7/R8 random: dropouts shorter than the hold never drop status
        void'($urandom(32'd1234));
        for (int it = 0; it < 24; it++) begin
            int ch, f, len;
            bit ok;
            f = 1 + int'($urandom % 15);
            ch = int'($urandom % 2);
            wr(ch == 0 ? 8'(f) : 8'(f << 4));
            det_pin = 2'b11;
            step(4);
            ok = 1'b1;
            for (int k = 0; k < 3; k++) begin
                len = 1 + int'($urandom % ((f * 15 - 1) * P - 4));
                det_pin[ch] = 1'b0;
                for (int c = 0; c < len + 3; c++) begin
                    @(negedge clk);
                    if (det_status[ch] != 1'b1 || irq != 1'b1) ok = 1'b0;
                    if (c == len - 1) det_pin[ch] = 1'b1;
                end
            end
            chk(ok, "R7 random dropout held", ok, 1);
            if (it % 6 == 0) measure(ch, f, "R3 R8 random full hold");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R3 actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule